// File: doc/BRIEF.md
# Processor idle-state controller

This block places the CPU of an 8-bit microcontroller core into a low-power idle state and brings it back out. Software starts idle by writing a 1 to the lowest bit of the power-control register. The writing instruction is the last one to run. From the next cycle the CPU clock enable is dropped, so every CPU register and every port output latch keeps its value. The timer, serial and interrupt logic keep their clock. The programmable counter array either pauses or keeps counting, depending on a configuration input. While the CPU clock is off, the address-latch strobe and the active-low program-store strobe are both forced high.

There are two ways out of idle:
- **Interrupt wake.** An enabled interrupt request clears the idle bit in hardware. The CPU clock then stays off for a fixed recovery time of three oscillator periods plus three instruction cycles of twelve oscillator periods each, 39 clocks in total. When the clock comes back, a one-cycle resume pulse is raised and the interrupt logic takes over.
- **Reset-pin wake.** The external reset pin must be seen high on four consecutive clocks. This raises a one-cycle soft-reset pulse, which clears the special-function registers and restarts the program counter at zero. Internal RAM is left untouched, and the CPU clock comes back at once.

Top module: `idle_power_ctrl`

## Requirements
- R1: During and right after synchronous reset: `cpu_clk_en`=1, `idle_flag`=0, both strobe forces 0, `resume_pulse`=0 and `soft_reset`=0. `periph_clk_en` is 0 while `rst` is high and 1 from the first clock after it falls.
- R2: In the run state, a `pwr_wr` cycle with `pwr_wdata[0]`=1 sets `idle_flag` and clears `cpu_clk_en` from the next cycle on. A write with bit 0 = 0 changes nothing.
- R3: `periph_clk_en` stays 1 through idle and recovery. While the CPU clock is off, `pca_clk_en` equals `pca_keep_run`. In the run state `pca_clk_en` is 1.
- R4: `ale_force_hi` and `psen_force_hi` are 1 exactly when `cpu_clk_en` is 0.
- R5: In idle, a request on line i with `irq_en[i]`=1 and `irq_global_en`=1 clears `idle_flag` at the next edge. `cpu_clk_en` then stays 0 for exactly 39 cycles after that edge.
- R6: A pending request whose own enable bit is 0, or any request while `irq_global_en`=0, leaves the core in idle.
- R7: `resume_pulse` is 1 for exactly one cycle: the first cycle in which `cpu_clk_en` is 1 again after an interrupt wake.
- R8: `rst_pin` sampled high on 4 consecutive clocks raises `soft_reset` for one cycle, starting after the 4th sample. In that same cycle `cpu_clk_en`=1 and `idle_flag`=0. Holding the pin high longer raises no further pulse.
- R9: A high run on `rst_pin` shorter than 4 samples is ignored. The qualifier restarts from zero on any low sample, so two separate 3-sample runs do not qualify.
- R10: If an enabled interrupt is present in the cycle of the idle write, the core spends one cycle in idle and then the 39-cycle recovery, 40 gated cycles in all, and then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high system reset |
| pwr_wr | input | 1 | Write strobe for the power-control register |
| pwr_wdata | input | 8 | Write data; bit 0 requests idle |
| pca_keep_run | input | 1 | 1: counter array keeps running in idle |
| irq_req | input | N_IRQ | Pending interrupt requests |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| irq_global_en | input | 1 | Global interrupt enable |
| rst_pin | input | 1 | External reset pin, already synchronized |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Timer, serial and interrupt clock enable |
| pca_clk_en | output | 1 | Counter-array clock enable |
| ale_force_hi | output | 1 | Hold the address-latch strobe high |
| psen_force_hi | output | 1 | Hold the program-store strobe high |
| idle_flag | output | 1 | Idle bit of the power-control register |
| resume_pulse | output | 1 | One-cycle pulse when the CPU clock returns after an interrupt wake |
| soft_reset | output | 1 | One-cycle pulse that clears the SFRs and restarts at address 0 |

## Verification
The main function is driven with several interrupt patterns:
- A request whose line enable is off, and one that arrives with the global enable off. These separate proper masking from plain OR-ing of requests.
- A fully enabled request during idle. This checks the 39-cycle recovery length.
- An enabled request present in the same cycle as the idle write. This shows the core still passes through one idle cycle rather than skipping idle or hanging.

The reset pin is driven with two 3-sample bursts split by a single low sample, which is rejected only if the qualifier restarts. A 4-sample run followed by a long hold checks that exactly one soft-reset pulse is produced. The counter-array enable is tried with both settings of its configuration input.

// File: rtl/idle_pkg.sv
package idle_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_RECOV = 2'd2
    } idle_state_t;

    typedef struct packed {
        logic cpu_en;
        logic strobe_hi;
        logic pca_en;
    } gate_ctl_t;

    function automatic int recov_len(input int osc_extra, input int n_instr,
                                     input int osc_per_instr);
        return osc_extra + n_instr * osc_per_instr;
    endfunction

    function automatic gate_ctl_t gate_decode(input idle_state_t st, input logic keep_run);
        gate_ctl_t g;
        g.cpu_en    = (st == ST_RUN);
        g.strobe_hi = (st != ST_RUN);
        g.pca_en    = (st == ST_RUN) | keep_run;
        return g;
    endfunction

endpackage

// File: rtl/idle_wake_detect.sv
module idle_wake_detect #(
    parameter int N_IRQ = 5
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             irq_global_en,
    output logic             wake
);
    logic [N_IRQ-1:0] live;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign live[i] = irq_req[i] & irq_en[i];
    end

    assign wake = irq_global_en & (|live);
endmodule

// File: rtl/idle_rst_qual.sv
module idle_rst_qual #(
    parameter int QUAL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic hit
);
    localparam int W = $clog2(QUAL + 1);
    localparam logic [W-1:0] TOP  = W'(QUAL);
    localparam logic [W-1:0] LAST = W'(QUAL - 1);

    logic [W-1:0] run_len;

    assign hit = pin && (run_len == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (!pin) begin
            run_len <= '0;
        end else if (run_len != TOP) begin
            run_len <= run_len + 1'b1;
        end
    end
endmodule

// File: rtl/idle_recov_timer.sv
module idle_recov_timer #(
    parameter int LEN = 39
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic done
);
    localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [W-1:0] START = W'(LEN - 1);

    logic [W-1:0] remain;

    assign done = (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= START;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/idle_power_ctrl.sv
module idle_power_ctrl
    import idle_pkg::*;
#(
    parameter int N_IRQ         = 5,
    parameter int OSC_EXTRA     = 3,
    parameter int WAIT_INSTR    = 3,
    parameter int OSC_PER_INSTR = 12,
    parameter int RST_QUAL      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_wr,
    input  logic [7:0]       pwr_wdata,
    input  logic             pca_keep_run,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             irq_global_en,
    input  logic             rst_pin,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             pca_clk_en,
    output logic             ale_force_hi,
    output logic             psen_force_hi,
    output logic             idle_flag,
    output logic             resume_pulse,
    output logic             soft_reset
);
    localparam int RECOV = recov_len(OSC_EXTRA, WAIT_INSTR, OSC_PER_INSTR);

    idle_state_t state, state_nx;
    gate_ctl_t   gate;
    logic        wake, rst_hit, recov_done, recov_load, idle_req;
    logic        unused_wdata;

    assign unused_wdata = ^pwr_wdata[7:1];
    assign idle_req     = pwr_wr && pwr_wdata[0];

    idle_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req      (irq_req),
        .irq_en       (irq_en),
        .irq_global_en(irq_global_en),
        .wake         (wake)
    );

    idle_rst_qual #(.QUAL(RST_QUAL)) u_qual (
        .clk(clk),
        .rst(rst),
        .pin(rst_pin),
        .hit(rst_hit)
    );

    idle_recov_timer #(.LEN(RECOV)) u_timer (
        .clk (clk),
        .rst (rst),
        .load(recov_load),
        .done(recov_done)
    );

    always_comb begin
        state_nx   = state;
        recov_load = 1'b0;
        if (rst_hit) begin
            state_nx = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN:   if (idle_req) state_nx = ST_IDLE;
                ST_IDLE:  if (wake) begin
                              state_nx   = ST_RECOV;
                              recov_load = 1'b1;
                          end
                ST_RECOV: if (recov_done) state_nx = ST_RUN;
                default:  state_nx = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_RUN;
            resume_pulse  <= 1'b0;
            soft_reset    <= 1'b0;
            periph_clk_en <= 1'b0;
        end else begin
            state         <= state_nx;
            resume_pulse  <= (state == ST_RECOV) && recov_done && !rst_hit;
            soft_reset    <= rst_hit;
            periph_clk_en <= 1'b1;
        end
    end

    assign gate          = gate_decode(state, pca_keep_run);
    assign cpu_clk_en    = gate.cpu_en;
    assign ale_force_hi  = gate.strobe_hi;
    assign psen_force_hi = gate.strobe_hi;
    assign pca_clk_en    = gate.pca_en;
    assign idle_flag     = (state == ST_IDLE);
endmodule

// File: rtl/idle_power_ctrl_chk.sv
module idle_power_ctrl_chk #(
    parameter int N_IRQ = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             pwr_wr,
    input logic [7:0]       pwr_wdata,
    input logic             pca_keep_run,
    input logic [N_IRQ-1:0] irq_req,
    input logic [N_IRQ-1:0] irq_en,
    input logic             irq_global_en,
    input logic             rst_pin,
    input logic             cpu_clk_en,
    input logic             periph_clk_en,
    input logic             pca_clk_en,
    input logic             ale_force_hi,
    input logic             psen_force_hi,
    input logic             idle_flag,
    input logic             resume_pulse,
    input logic             soft_reset
);
    logic any_wake;
    assign any_wake = irq_global_en && (|(irq_req & irq_en));

    p_gate_after_write_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && pwr_wr && pwr_wdata[0] && !rst_pin) |=> !cpu_clk_en);

    p_pca_pause_r3: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk_en && !pca_keep_run) |-> !pca_clk_en);

    p_periph_on_r3: assert property (@(posedge clk) disable iff (rst)
        !cpu_clk_en |-> periph_clk_en);

    p_strobe_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !cpu_clk_en |-> (ale_force_hi && psen_force_hi));

    p_irq_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (idle_flag && any_wake && !rst_pin) |=> (!idle_flag && !cpu_clk_en));

    p_masked_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (idle_flag && !any_wake && !rst_pin) |=> idle_flag);

    p_resume_single_r7: assert property (@(posedge clk) disable iff (rst)
        resume_pulse |=> !resume_pulse);

    p_resume_clock_r7: assert property (@(posedge clk) disable iff (rst)
        resume_pulse |-> (cpu_clk_en && !idle_flag));

    p_softrst_state_r8: assert property (@(posedge clk) disable iff (rst)
        soft_reset |-> (cpu_clk_en && !idle_flag));

    // R9: a qualified pulse needs the pin high on the preceding samples
    p_softrst_pin_r9: assert property (@(posedge clk) disable iff (rst)
        soft_reset |-> ($past(rst_pin) && $past(rst_pin, 2)));
endmodule

bind idle_power_ctrl idle_power_ctrl_chk #(.N_IRQ(N_IRQ)) u_idle_chk (
    .clk          (clk),
    .rst          (rst),
    .pwr_wr       (pwr_wr),
    .pwr_wdata    (pwr_wdata),
    .pca_keep_run (pca_keep_run),
    .irq_req      (irq_req),
    .irq_en       (irq_en),
    .irq_global_en(irq_global_en),
    .rst_pin      (rst_pin),
    .cpu_clk_en   (cpu_clk_en),
    .periph_clk_en(periph_clk_en),
    .pca_clk_en   (pca_clk_en),
    .ale_force_hi (ale_force_hi),
    .psen_force_hi(psen_force_hi),
    .idle_flag    (idle_flag),
    .resume_pulse (resume_pulse),
    .soft_reset   (soft_reset)
);

// File: tb/test_idle_power_ctrl.sv
`timescale 1ns/1ps
module test_idle_power_ctrl;
    localparam int NI    = 5;
    localparam int RLEN  = 39;
    localparam int QLEN  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_wr = 1'b0;
    logic [7:0] pwr_wdata = 8'h00;
    logic pca_keep_run = 1'b0;
    logic [NI-1:0] irq_req = '0;
    logic [NI-1:0] irq_en = '0;
    logic irq_global_en = 1'b0;
    logic rst_pin = 1'b0;
    logic cpu_clk_en, periph_clk_en, pca_clk_en, ale_force_hi, psen_force_hi;
    logic idle_flag, resume_pulse, soft_reset;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    idle_power_ctrl #(.N_IRQ(NI)) i_idle_power_ctrl (
        .clk(clk), .rst(rst), .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata),
        .pca_keep_run(pca_keep_run), .irq_req(irq_req), .irq_en(irq_en),
        .irq_global_en(irq_global_en), .rst_pin(rst_pin),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .pca_clk_en(pca_clk_en), .ale_force_hi(ale_force_hi),
        .psen_force_hi(psen_force_hi), .idle_flag(idle_flag),
        .resume_pulse(resume_pulse), .soft_reset(soft_reset)
    );

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: mode 0 running, 1 idle, 2 recovering
    int  m_mode = 0;
    int  m_left = 0;
    int  m_high = 0;
    bit  m_resume = 0, m_soft = 0, m_periph = 0;

    always @(posedge clk) begin
        bit wk, q;
        if (rst) begin
            m_mode = 0; m_left = 0; m_high = 0;
            m_resume = 0; m_soft = 0; m_periph = 0;
        end else begin
            wk = irq_global_en && ((irq_req & irq_en) != 0);
            q  = rst_pin && (m_high == QLEN - 1);
            m_high   = rst_pin ? ((m_high < QLEN) ? m_high + 1 : m_high) : 0;
            m_periph = 1;
            m_soft   = q;
            m_resume = 0;
            if (q) begin
                m_mode = 0;
            end else if (m_mode == 0) begin
                if (pwr_wr && pwr_wdata[0]) m_mode = 1;
            end else if (m_mode == 1) begin
                if (wk) begin m_mode = 2; m_left = RLEN - 1; end
            end else begin
                if (m_left == 0) begin m_mode = 0; m_resume = 1; end
                else m_left--;
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            check("R5", "cpu_clk_en", int'(cpu_clk_en), int'(m_mode == 0));
            check("R2", "idle_flag", int'(idle_flag), int'(m_mode == 1));
            check("R3", "periph_clk_en", int'(periph_clk_en), int'(m_periph));
            check("R3", "pca_clk_en", int'(pca_clk_en), int'(m_mode == 0 || pca_keep_run));
            check("R4", "ale_force_hi", int'(ale_force_hi), int'(m_mode != 0));
            check("R4", "psen_force_hi", int'(psen_force_hi), int'(m_mode != 0));
            check("R7", "resume_pulse", int'(resume_pulse), int'(m_resume));
            check("R8", "soft_reset", int'(soft_reset), int'(m_soft));
        end
    end

    task automatic nxt(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic write_pcon(input logic [7:0] d);
        pwr_wr = 1'b1; pwr_wdata = d;
        nxt();
        pwr_wr = 1'b0; pwr_wdata = 8'h00;
    endtask

    initial begin
        int n;
        nxt(3);
        @(negedge clk);
        check("R1", "reset cpu_clk_en", int'(cpu_clk_en), 1);
        check("R1", "reset periph_clk_en", int'(periph_clk_en), 0);
        check("R1", "reset soft_reset", int'(soft_reset), 0);
        nxt();
        rst = 1'b0;
        nxt();
        @(negedge clk);
        check("R1", "post reset periph_clk_en", int'(periph_clk_en), 1);
        check("R1", "post reset idle_flag", int'(idle_flag), 0);
        nxt();

        // R2: bit 0 clear has no effect
        write_pcon(8'hFE);
        @(negedge clk);
        check("R2", "write0 keeps running", int'(cpu_clk_en), 1);
        nxt();

        // R2/R3: enter idle with counter array paused
        write_pcon(8'h01);
        @(negedge clk);
        check("R2", "idle entered", int'(idle_flag), 1);
        check("R3", "pca paused", int'(pca_clk_en), 0);
        nxt(3);

        // R6: masked by line enable, then by global enable
        irq_req = 5'b00100; irq_en = 5'b11011; irq_global_en = 1'b1;
        nxt(4);
        irq_en = 5'b00100; irq_global_en = 1'b0;
        nxt(4);
        @(negedge clk);
        check("R6", "masked requests keep idle", int'(idle_flag), 1);
        nxt();

        // R5/R7: enabled interrupt wake
        irq_global_en = 1'b1;
        @(posedge clk);
        n = 0;
        @(negedge clk);
        check("R5", "idle bit cleared by irq", int'(idle_flag), 0);
        while (!cpu_clk_en && n < 200) begin n++; @(negedge clk); end
        check("R5", "recovery gated cycles", n, RLEN);
        check("R7", "resume on first clocked cycle", int'(resume_pulse), 1);
        nxt();
        irq_req = '0; irq_en = '0; irq_global_en = 1'b0;
        nxt(2);

        // R3: counter array runs in idle
        pca_keep_run = 1'b1;
        write_pcon(8'h81);
        @(negedge clk);
        check("R3", "pca runs in idle", int'(pca_clk_en), 1);
        nxt(2);

        // R9: two 3-sample bursts split by one low sample
        rst_pin = 1'b1; nxt(3);
        rst_pin = 1'b0; nxt(1);
        rst_pin = 1'b1; nxt(3);
        rst_pin = 1'b0;
        @(negedge clk);
        check("R9", "short bursts ignored", int'(idle_flag), 1);
        nxt(2);

        // R8: qualified reset-pin exit, then a long hold
        rst_pin = 1'b1;
        nxt(3);
        @(negedge clk);
        check("R8", "no pulse after 3 samples", int'(soft_reset), 0);
        @(negedge clk);
        check("R8", "pulse after 4th sample", int'(soft_reset), 1);
        check("R8", "clock back with pulse", int'(cpu_clk_en), 1);
        nxt(6);
        @(negedge clk);
        check("R8", "no repeat while held", int'(soft_reset), 0);
        nxt();
        rst_pin = 1'b0;
        pca_keep_run = 1'b0;
        nxt(2);

        // R10: wake present in the cycle of the idle write
        irq_req = 5'b00001; irq_en = 5'b00001; irq_global_en = 1'b1;
        write_pcon(8'h01);
        n = 0;
        @(negedge clk);
        check("R10", "one idle cycle", int'(idle_flag), 1);
        while (!cpu_clk_en && n < 200) begin n++; @(negedge clk); end
        check("R10", "total gated cycles", n, RLEN + 1);
        check("R10", "resumes", int'(resume_pulse), 1);
        nxt(3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule